// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of the serial link of a small page-organised flash device. It watches the serial clock, chip select and serial data input pins and oversamples them with a faster system clock. From that traffic it recovers an 8-bit opcode and the 24-bit address that follows it. It drives the serial data output, with a separate output-enable that stands for a three-state pin. Only clock polarity/phase combinations 0 and 3 are accepted: data is taken on the rising clock edge and launched on the falling edge, whatever level the clock idles at.

What follows the opcode depends on the opcode itself. A status opcode streams a status byte over and over. Read opcodes skip a per-opcode number of dummy bits and then stream bytes from the array or from one of two page buffers, each with its own address wrap rule. Write opcodes turn every received byte into a one-cycle buffer write strobe. Transfer, compare, program and rewrite opcodes do nothing while selected: the array controller gets a one-cycle launch request only when chip select rises after a complete command.

Top module: `dfe_front`

## Requirements
- R1: SI is taken on rising SCK edges and SO moves only on falling SCK edges, most significant bit first. The first output bit appears on the falling edge that follows the last command bit, never in the same SCK cycle. Clock modes 0 and 3 both work.
- R2: While CS_n is high, SCK and SI are ignored and spi_so_oe is low. A rising CS_n ends any read or write stream.
- R3: Opcodes 57h and D7h take no address. Output is the byte {ready, compare-miss, density[2:0], 3'b000} (density defaults to 3'b011), repeated for as long as clocks arrive. Each repetition re-samples stat_ready and stat_cmp_miss.
- R4: Every other accepted opcode is followed by 24 address bits, MSB first. Bits 23:20 are ignored, bits 19:9 form the page and bits 8:0 the byte offset.
- R5: After the address, opcodes 68h, E8h, 52h and D2h skip 32 dummy bits, while 54h, D4h (buffer 1) and 56h, D6h (buffer 2) skip 8. Output then starts, and spi_so_oe stays low through the dummy bits. rd_sel is 0 for the array, 1 for buffer 1 and 2 for buffer 2.
- R6: Opcodes 68h and E8h step from offset PAGE_BYTES-1 to offset 0 of the next page, and from the last page to page 0, with no gap.
- R7: Opcodes 52h and D2h wrap from offset PAGE_BYTES-1 to offset 0 of the same page.
- R8: Buffer reads and writes wrap from offset PAGE_BYTES-1 to offset 0.
- R9: Opcodes 53h, 55h, 60h, 61h, 83h, 86h, 88h, 89h, 58h, 59h, 82h and 85h produce a single-cycle op_valid carrying the opcode and page. It fires only after CS_n rises, and only if all 24 address bits were received.
- R10: After the address of 84h or 82h (wr_buf=0) or of 87h or 85h (wr_buf=1), each complete received byte gives one wr_valid pulse with its data and offset. A trailing partial byte is dropped.
- R11: An unknown opcode, or a CS_n rise before the address is complete, causes no op_valid and no wr_valid, and leaves spi_so_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so (low means high impedance) |
| stat_ready | input | 1 | Controller idle flag for the status byte |
| stat_cmp_miss | input | 1 | Result of the last compare, 1 on mismatch |
| rd_sel | output | 2 | Read source: 0 array, 1 buffer 1, 2 buffer 2 |
| rd_page | output | PAGE_W | Page of the byte to be read next |
| rd_offs | output | BYTE_W | Offset of the byte to be read next |
| rd_data | input | 8 | Byte at rd_sel/rd_page/rd_offs |
| wr_valid | output | 1 | One-cycle buffer write strobe |
| wr_buf | output | 1 | Target buffer of the write, 0 or 1 |
| wr_offs | output | BYTE_W | Buffer offset of the write |
| wr_data | output | 8 | Byte to write |
| op_valid | output | 1 | One-cycle array operation launch |
| op_opcode | output | 8 | Opcode of the launched operation |
| op_page | output | PAGE_W | Page of the launched operation |

## Verification
The status stream is read in both clock modes, and the status inputs are changed between two bytes of one stream to tell a fresh snapshot from a latched one. Reads start one or two bytes before a boundary in each source, so the same start offset yields a next-page step, a same-page wrap or a buffer wrap, and those three are told apart by the data returned. Writes and array operations are ended with complete commands, truncated addresses, trailing partial bytes and undefined opcodes, which separates a launch at chip-select rise from a launch at the last bit and shows which cases must leave no trace. Clocking with chip select high before a read shows that deselected traffic leaves no state behind.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    localparam int ADDR_BITS = 24;

    typedef enum logic [2:0] {
        K_NONE, K_STATUS, K_ARR_READ, K_PAGE_READ,
        K_BUF_READ, K_BUF_WRITE, K_PAGE_PROG, K_ARRAY_OP
    } kind_e;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_BUF1  = 2'd1,
        SRC_BUF2  = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_DUMMY, PH_RDATA,
        PH_WDATA, PH_STAT, PH_ARMED, PH_DROP
    } phase_e;

    typedef struct packed {
        kind_e      kind;
        logic       alt_buf;
        logic [5:0] dummy;
    } cmd_s;

    function automatic cmd_s decode_opc(input logic [7:0] opc);
        cmd_s c;
        c.kind    = K_NONE;
        c.alt_buf = 1'b0;
        c.dummy   = 6'd0;
        case (opc)
            8'h57, 8'hD7: c.kind = K_STATUS;
            8'h68, 8'hE8: begin c.kind = K_ARR_READ;  c.dummy = 6'd32; end
            8'h52, 8'hD2: begin c.kind = K_PAGE_READ; c.dummy = 6'd32; end
            8'h54, 8'hD4: begin c.kind = K_BUF_READ;  c.dummy = 6'd8;  end
            8'h56, 8'hD6: begin c.kind = K_BUF_READ;  c.dummy = 6'd8; c.alt_buf = 1'b1; end
            8'h84:        c.kind = K_BUF_WRITE;
            8'h87:        begin c.kind = K_BUF_WRITE; c.alt_buf = 1'b1; end
            8'h82:        c.kind = K_PAGE_PROG;
            8'h85:        begin c.kind = K_PAGE_PROG; c.alt_buf = 1'b1; end
            8'h53, 8'h60, 8'h83, 8'h88, 8'h58: c.kind = K_ARRAY_OP;
            8'h55, 8'h61, 8'h86, 8'h89, 8'h59: begin c.kind = K_ARRAY_OP; c.alt_buf = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dfe_sync.sv
module dfe_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dfe_addr_step.sv
module dfe_addr_step
    import dfe_pkg::*;
#(
    parameter int PAGE_W     = 11,
    parameter int BYTE_W     = 9,
    parameter int PAGE_BYTES = 264
) (
    input  kind_e              kind,
    input  logic [PAGE_W-1:0]  page,
    input  logic [BYTE_W-1:0]  offs,
    output logic [PAGE_W-1:0]  page_nx,
    output logic [BYTE_W-1:0]  offs_nx
);
    localparam logic [BYTE_W-1:0] LAST_OFFS = BYTE_W'(PAGE_BYTES - 1);

    always_comb begin
        page_nx = page;
        offs_nx = offs + 1'b1;
        if (offs == LAST_OFFS) begin
            offs_nx = '0;
            // only the continuous array read walks into the next page
            if (kind == K_ARR_READ) page_nx = page + 1'b1;
        end
    end
endmodule

// File: rtl/dfe_tx.sv
module dfe_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       shift_en,
    input  logic [7:0] load_byte,
    output logic       so,
    output logic       oe,
    output logic       load_now
);
    logic [2:0] pos_q;
    logic [6:0] rest_q;

    assign load_now = shift_en && (pos_q == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos_q  <= '0;
            rest_q <= '0;
            so     <= 1'b0;
            oe     <= 1'b0;
        end else if (shift_en) begin
            oe    <= 1'b1;
            pos_q <= pos_q + 1'b1;
            if (pos_q == 3'd0) begin
                {so, rest_q} <= load_byte;
            end else begin
                so     <= rest_q[6];
                rest_q <= {rest_q[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/dfe_front.sv
module dfe_front
    import dfe_pkg::*;
#(
    parameter int         PAGE_W      = 11,
    parameter int         BYTE_W      = 9,
    parameter int         PAGE_BYTES  = 264,
    parameter logic [2:0] DENSITY     = 3'b011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              stat_ready,
    input  logic              stat_cmp_miss,
    output logic [1:0]        rd_sel,
    output logic [PAGE_W-1:0] rd_page,
    output logic [BYTE_W-1:0] rd_offs,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic              wr_buf,
    output logic [BYTE_W-1:0] wr_offs,
    output logic [7:0]        wr_data,
    output logic              op_valid,
    output logic [7:0]        op_opcode,
    output logic [PAGE_W-1:0] op_page
);
    localparam int LOC_W = PAGE_W + BYTE_W;   // page+offset part of the address
    localparam int SH_W  = LOC_W - 1;
    localparam logic [5:0] ADDR_LAST = 6'(ADDR_BITS - 1);

    // pin synchronisation and edge detection
    logic       cs_s, sck_s, si_s, cs_d, sck_d;
    dfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_si}),
        .q   ({cs_s, sck_s, si_s})
    );

    logic sel, sck_rise, sck_fall, cs_rise;
    assign sel      = ~cs_s;
    assign sck_rise =  sck_s & ~sck_d;
    assign sck_fall = ~sck_s &  sck_d;
    assign cs_rise  =  cs_s  & ~cs_d;

    // command state
    phase_e            ph_q;
    cmd_s              cmd_q;
    logic [7:0]        opc_q;
    logic [5:0]        cnt_q;
    logic [SH_W-1:0]   sh_q;
    logic [PAGE_W-1:0] page_q;
    logic [BYTE_W-1:0] offs_q;

    cmd_s              cmd_nx;
    logic [LOC_W-1:0]  loc_in;
    assign loc_in = {sh_q, si_s};
    assign cmd_nx = decode_opc(loc_in[7:0]);

    logic [PAGE_W-1:0] page_nx;
    logic [BYTE_W-1:0] offs_nx;
    dfe_addr_step #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES)) i_step (
        .kind    (cmd_q.kind),
        .page    (page_q),
        .offs    (offs_q),
        .page_nx (page_nx),
        .offs_nx (offs_nx)
    );

    // output shifter
    logic       tx_en, tx_load;
    logic [7:0] status_byte, tx_byte;
    assign status_byte = {stat_ready, stat_cmp_miss, DENSITY, 3'b000};
    assign tx_byte     = (ph_q == PH_STAT) ? status_byte : rd_data;
    assign tx_en       = sel && sck_fall && (ph_q == PH_RDATA || ph_q == PH_STAT);

    dfe_tx i_tx (
        .clk       (clk),
        .rst       (rst),
        .clear     (~sel),
        .shift_en  (tx_en),
        .load_byte (tx_byte),
        .so        (spi_so),
        .oe        (spi_so_oe),
        .load_now  (tx_load)
    );

    always_comb begin
        rd_sel = SRC_ARRAY;
        if (cmd_q.kind == K_BUF_READ) rd_sel = cmd_q.alt_buf ? SRC_BUF2 : SRC_BUF1;
    end
    assign rd_page = page_q;
    assign rd_offs = offs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d      <= 1'b1;
            sck_d     <= 1'b0;
            ph_q      <= PH_OPC;
            cmd_q     <= '{kind: K_NONE, alt_buf: 1'b0, dummy: 6'd0};
            opc_q     <= '0;
            cnt_q     <= '0;
            sh_q      <= '0;
            page_q    <= '0;
            offs_q    <= '0;
            wr_valid  <= 1'b0;
            wr_buf    <= 1'b0;
            wr_offs   <= '0;
            wr_data   <= '0;
            op_valid  <= 1'b0;
            op_opcode <= '0;
            op_page   <= '0;
        end else begin
            cs_d     <= cs_s;
            sck_d    <= sck_s;
            wr_valid <= 1'b0;
            op_valid <= 1'b0;
            if (cs_rise) begin
                // launch happens here, never on the last shifted bit
                if (ph_q == PH_ARMED || (ph_q == PH_WDATA && cmd_q.kind == K_PAGE_PROG)) begin
                    op_valid  <= 1'b1;
                    op_opcode <= opc_q;
                    op_page   <= page_q;
                end
                ph_q  <= PH_OPC;
                cnt_q <= '0;
            end else if (!sel) begin
                ph_q  <= PH_OPC;
                cnt_q <= '0;
            end else if (sck_rise) begin
                sh_q  <= loc_in[SH_W-1:0];
                cnt_q <= cnt_q + 1'b1;
                case (ph_q)
                    PH_OPC: if (cnt_q == 6'd7) begin
                        opc_q <= loc_in[7:0];
                        cmd_q <= cmd_nx;
                        cnt_q <= '0;
                        case (cmd_nx.kind)
                            K_NONE:   ph_q <= PH_DROP;
                            K_STATUS: ph_q <= PH_STAT;
                            default:  ph_q <= PH_ADDR;
                        endcase
                    end
                    PH_ADDR: if (cnt_q == ADDR_LAST) begin
                        page_q <= loc_in[BYTE_W +: PAGE_W];
                        offs_q <= loc_in[BYTE_W-1:0];
                        cnt_q  <= '0;
                        case (cmd_q.kind)
                            K_BUF_WRITE, K_PAGE_PROG: ph_q <= PH_WDATA;
                            K_ARRAY_OP:               ph_q <= PH_ARMED;
                            default:                  ph_q <= PH_DUMMY;
                        endcase
                    end
                    PH_DUMMY: if (cnt_q == 6'(cmd_q.dummy - 6'd1)) begin
                        ph_q  <= PH_RDATA;
                        cnt_q <= '0;
                    end
                    PH_WDATA: if (cnt_q == 6'd7) begin
                        wr_valid <= 1'b1;
                        wr_data  <= loc_in[7:0];
                        wr_buf   <= cmd_q.alt_buf;
                        wr_offs  <= offs_q;
                        offs_q   <= offs_nx;
                        page_q   <= page_nx;
                        cnt_q    <= '0;
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end else if (tx_load) begin
                offs_q <= offs_nx;
                page_q <= page_nx;
            end
        end
    end
endmodule

// File: rtl/dfe_front_chk.sv
module dfe_front_chk (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_so_oe,
    input logic op_valid,
    input logic wr_valid
);
    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_so_oe); // R2
    AST_WR_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !$past(spi_cs_n, 3)); // R2
    AST_OP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid); // R9
    AST_OP_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(spi_cs_n, 3)); // R9
    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R10
    AST_WR_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !spi_so_oe); // R10
endmodule

bind dfe_front dfe_front_chk i_dfe_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_so_oe (spi_so_oe),
    .op_valid  (op_valid),
    .wr_valid  (wr_valid)
);

// File: tb/test_dfe_front.sv
module test_dfe_front;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic        ready = 1'b1, cmp_miss = 1'b0;
    logic        so, so_oe;
    logic [1:0]  rd_sel;
    logic [10:0] rd_page;
    logic [8:0]  rd_offs;
    logic [7:0]  rd_data;
    logic        wr_valid, wr_buf;
    logic [8:0]  wr_offs;
    logic [7:0]  wr_data;
    logic        op_valid;
    logic [7:0]  op_opcode;
    logic [10:0] op_page;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [7:0] mem_f(input logic [1:0] s, input logic [10:0] pg, input logic [8:0] of);
        logic [15:0] v;
        v = ((s == 2'd0) ? 16'(pg) * 16'd7 : 16'd0) + 16'(of) * 16'd3 + 16'(s) * 16'd101;
        return v[7:0];
    endfunction
    assign rd_data = mem_f(rd_sel, rd_page, rd_offs);

    dfe_front i_dfe_front (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .stat_ready(ready), .stat_cmp_miss(cmp_miss),
        .rd_sel(rd_sel), .rd_page(rd_page), .rd_offs(rd_offs), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_buf(wr_buf), .wr_offs(wr_offs), .wr_data(wr_data),
        .op_valid(op_valid), .op_opcode(op_opcode), .op_page(op_page)
    );

    // event capture
    int          op_cnt = 0, wr_cnt = 0;
    logic [7:0]  op_opc_log [16];
    logic [10:0] op_pg_log  [16];
    logic [7:0]  wr_d_log   [16];
    logic        wr_b_log   [16];
    logic [8:0]  wr_o_log   [16];
    always @(negedge clk) begin
        if (op_valid) begin
            op_opc_log[op_cnt % 16] = op_opcode;
            op_pg_log[op_cnt % 16]  = op_page;
            op_cnt = op_cnt + 1;
        end
        if (wr_valid) begin
            wr_d_log[wr_cnt % 16] = wr_data;
            wr_b_log[wr_cnt % 16] = wr_buf;
            wr_o_log[wr_cnt % 16] = wr_offs;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input bit m3);
        @(negedge clk) sck = m3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end(input bit m3);
        if (!m3) begin
            @(negedge clk) sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic bit_x(input logic b, output logic r, output logic oe);
        @(negedge clk) begin sck = 1'b0; si = b; end
        wait_clk(HALF);
        r  = so;
        oe = so_oe;
        sck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        logic r, oe;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], r, oe);
            rx[i]  = r;
            oe_any = oe_any | oe;
        end
    endtask

    task automatic send_addr(input logic [3:0] rsv, input logic [10:0] pg, input logic [8:0] of, output logic oe_any);
        logic [23:0] a;
        logic [7:0]  rx;
        logic        oe;
        a = {rsv, pg, of};
        oe_any = 1'b0;
        for (int i = 2; i >= 0; i--) begin
            byte_x(a[i*8 +: 8], rx, oe);
            oe_any = oe_any | oe;
        end
    endtask

    task automatic t_reset;
        chk("R2", "so_oe after reset", 32'(so_oe), 32'd0);
        chk("R9", "op_valid after reset", 32'(op_valid), 32'd0);
        chk("R10", "wr_valid after reset", 32'(wr_valid), 32'd0);
    endtask

    task automatic t_status_mode0;
        logic [7:0] rx;
        logic oe;
        cs_begin(1'b0);
        byte_x(8'hD7, rx, oe);
        chk("R1", "oe before first output fall", 32'(so_oe), 32'd0);
        chk("R1", "oe during opcode", 32'(oe), 32'd0);
        byte_x(8'h00, rx, oe);
        chk("R3", "status byte 1", 32'(rx), 32'h98);
        chk("R1", "oe during status", 32'(oe), 32'd1);
        ready = 1'b0; cmp_miss = 1'b1;
        byte_x(8'h00, rx, oe);
        chk("R3", "status byte 2 fresh snapshot", 32'(rx), 32'h58);
        ready = 1'b1; cmp_miss = 1'b0;
        byte_x(8'h00, rx, oe);
        chk("R3", "status byte 3", 32'(rx), 32'h98);
        cs_end(1'b0);
        chk("R2", "oe after CS rise", 32'(so_oe), 32'd0);
    endtask

    task automatic t_status_mode3;
        logic [7:0] rx;
        logic oe;
        cs_begin(1'b1);
        byte_x(8'h57, rx, oe);
        byte_x(8'h00, rx, oe);
        chk("R1", "mode 3 status byte", 32'(rx), 32'h98);
        cs_end(1'b1);
    endtask

    task automatic t_array_read;
        logic [7:0] rx;
        logic oe, oe_d;
        cs_begin(1'b0);
        byte_x(8'hE8, rx, oe);
        send_addr(4'hF, 11'd2047, 9'd262, oe);
        chk("R4", "oe during address", 32'(oe), 32'd0);
        oe_d = 1'b0;
        for (int i = 0; i < 4; i++) begin
            byte_x(8'h00, rx, oe);
            oe_d = oe_d | oe;
        end
        chk("R5", "oe during 32 dummy bits", 32'(oe_d), 32'd0);
        byte_x(8'h00, rx, oe);
        chk("R4", "array read first byte", 32'(rx), 32'(mem_f(2'd0, 11'd2047, 9'd262)));
        byte_x(8'h00, rx, oe);
        chk("R6", "array read last byte of page", 32'(rx), 32'(mem_f(2'd0, 11'd2047, 9'd263)));
        byte_x(8'h00, rx, oe);
        chk("R6", "array wrap to page 0", 32'(rx), 32'(mem_f(2'd0, 11'd0, 9'd0)));
        byte_x(8'h00, rx, oe);
        chk("R6", "array continues page 0", 32'(rx), 32'(mem_f(2'd0, 11'd0, 9'd1)));
        cs_end(1'b0);
    endtask

    task automatic t_page_read;
        logic [7:0] rx;
        logic oe;
        cs_begin(1'b1);
        byte_x(8'h52, rx, oe);
        send_addr(4'h0, 11'd5, 9'd262, oe);
        for (int i = 0; i < 4; i++) byte_x(8'h00, rx, oe);
        byte_x(8'h00, rx, oe);
        chk("R5", "page read first byte", 32'(rx), 32'(mem_f(2'd0, 11'd5, 9'd262)));
        byte_x(8'h00, rx, oe);
        byte_x(8'h00, rx, oe);
        chk("R7", "page read wraps in page", 32'(rx), 32'(mem_f(2'd0, 11'd5, 9'd0)));
        cs_end(1'b1);
    endtask

    task automatic t_buf_read;
        logic [7:0] rx;
        logic oe;
        cs_begin(1'b0);
        byte_x(8'hD6, rx, oe);
        send_addr(4'h0, 11'd0, 9'd263, oe);
        byte_x(8'h00, rx, oe);
        chk("R5", "oe during 8 dummy bits", 32'(oe), 32'd0);
        byte_x(8'h00, rx, oe);
        chk("R5", "buffer 2 read byte", 32'(rx), 32'(mem_f(2'd2, 11'd0, 9'd263)));
        byte_x(8'h00, rx, oe);
        chk("R8", "buffer read wrap", 32'(rx), 32'(mem_f(2'd2, 11'd0, 9'd0)));
        cs_end(1'b0);
    endtask

    task automatic t_buf_write;
        logic [7:0] rx;
        logic oe, r;
        int w0, o0;
        w0 = wr_cnt; o0 = op_cnt;
        cs_begin(1'b0);
        byte_x(8'h84, rx, oe);
        send_addr(4'h0, 11'd0, 9'd262, oe);
        byte_x(8'hA1, rx, oe);
        byte_x(8'hB2, rx, oe);
        byte_x(8'hC3, rx, oe);
        for (int i = 0; i < 4; i++) bit_x(1'b1, r, oe);
        cs_end(1'b0);
        chk("R10", "write count (partial dropped)", 32'(wr_cnt - w0), 32'd3);
        chk("R10", "write 0 data", 32'(wr_d_log[w0 % 16]), 32'hA1);
        chk("R10", "write 0 offset", 32'(wr_o_log[w0 % 16]), 32'd262);
        chk("R10", "write 0 buffer", 32'(wr_b_log[w0 % 16]), 32'd0);
        chk("R8", "write 2 wrapped offset", 32'(wr_o_log[(w0 + 2) % 16]), 32'd0);
        chk("R10", "write 2 data", 32'(wr_d_log[(w0 + 2) % 16]), 32'hC3);
        chk("R9", "no launch for buffer write", 32'(op_cnt - o0), 32'd0);
    endtask

    task automatic t_page_prog;
        logic [7:0] rx;
        logic oe;
        int w0, o0;
        w0 = wr_cnt; o0 = op_cnt;
        cs_begin(1'b0);
        byte_x(8'h85, rx, oe);
        send_addr(4'h0, 11'd77, 9'd0, oe);
        byte_x(8'h3C, rx, oe);
        chk("R9", "no launch before CS rise", 32'(op_cnt - o0), 32'd0);
        cs_end(1'b0);
        chk("R9", "program launch count", 32'(op_cnt - o0), 32'd1);
        chk("R9", "program launch opcode", 32'(op_opc_log[o0 % 16]), 32'h85);
        chk("R9", "program launch page", 32'(op_pg_log[o0 % 16]), 32'd77);
        chk("R10", "program stream buffer", 32'(wr_b_log[w0 % 16]), 32'd1);
        chk("R10", "program stream data", 32'(wr_d_log[w0 % 16]), 32'h3C);
    endtask

    task automatic t_transfer;
        logic [7:0] rx;
        logic oe;
        int o0;
        o0 = op_cnt;
        cs_begin(1'b1);
        byte_x(8'h53, rx, oe);
        send_addr(4'h0, 11'd300, 9'd0, oe);
        chk("R9", "transfer not launched while selected", 32'(op_cnt - o0), 32'd0);
        cs_end(1'b1);
        chk("R9", "transfer launch count", 32'(op_cnt - o0), 32'd1);
        chk("R9", "transfer opcode", 32'(op_opc_log[o0 % 16]), 32'h53);
        chk("R9", "transfer page", 32'(op_pg_log[o0 % 16]), 32'd300);
    endtask

    task automatic t_early_cs;
        logic [7:0] rx;
        logic oe;
        int o0;
        o0 = op_cnt;
        cs_begin(1'b0);
        byte_x(8'h60, rx, oe);
        byte_x(8'h00, rx, oe);
        byte_x(8'h12, rx, oe);
        cs_end(1'b0);
        chk("R11", "short compare not launched", 32'(op_cnt - o0), 32'd0);
    endtask

    task automatic t_unknown;
        logic [7:0] rx;
        logic oe, oe_any;
        int o0, w0;
        o0 = op_cnt; w0 = wr_cnt;
        oe_any = 1'b0;
        cs_begin(1'b0);
        byte_x(8'hFF, rx, oe);
        for (int i = 0; i < 5; i++) begin
            byte_x(8'hA5, rx, oe);
            oe_any = oe_any | oe;
        end
        cs_end(1'b0);
        chk("R11", "unknown opcode oe", 32'(oe_any), 32'd0);
        chk("R11", "unknown opcode launches", 32'(op_cnt - o0), 32'd0);
        chk("R11", "unknown opcode writes", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_deselected;
        logic [7:0] rx;
        logic [7:0] junk;
        logic oe_seen;
        junk = 8'hE8;
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) begin sck = 1'b0; si = junk[i]; end
            wait_clk(HALF);
            oe_seen = oe_seen | so_oe;
            sck = 1'b1;
            wait_clk(HALF);
        end
        chk("R2", "oe while deselected", 32'(oe_seen), 32'd0);
        cs_begin(1'b0);
        byte_x(8'hD7, rx, oe_seen);
        byte_x(8'h00, rx, oe_seen);
        chk("R2", "deselected clocks left no state", 32'(rx), 32'h98);
        cs_end(1'b0);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_status_mode0();
        t_status_mode3();
        t_array_read();
        t_page_read();
        t_buf_read();
        t_buf_write();
        t_page_prog();
        t_transfer();
        t_early_cs();
        t_unknown();
        t_deselected();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule